// File: doc/BRIEF.md
# Serial EEPROM Station Word Loader

This block fetches a short, fixed run of 16-bit words from a three-wire serial EEPROM after a single start pulse. The usual job is pulling a 48-bit station address out of the memory at power-up. The block drives chip select, serial clock and the data line into the memory, and it samples the data line coming back.

For every word the block first parks all three outgoing lines low for one phase. It then sends a read opcode and a word address, and clocks in sixteen data bits. Each word lands in its own 16-bit slot of the result. A busy flag covers the whole run, and a one-cycle done pulse marks the end.

All timing on the memory side is built from phases, and a phase lasts a programmable number of system clock cycles. That lets one design meet the memory's slowest setup and hold limits at any system clock rate.

Top module: `romld_top`

## Requirements
- R1: After reset, romCs, romClk, romDi, busy and done are all 0 and stationWord is zero.
- R2: Before every word, romCs, romClk and romDi are all low for one phase. After every word they are low for one more phase, so between two consecutive words of a run the lines are low for exactly two phases.
- R3: Each word frame starts with the opcode bits 1, 1, 0 in that order. A 5-bit word address follows at once, most significant bit first. The three words of a run use addresses 10, 11 and 12, in that order.
- R4: Each bit sent to the memory first sets romDi with romClk low. romClk then stays high for exactly one phase, then goes low again. romDi does not change while romClk is high.
- R5: Each word reads exactly 16 data bits, most significant bit first. For each bit romClk is high for two phases, and romDo is sampled at the end of the second high phase. Each new bit shifts in at the least significant end.
- R6: romCs stays high without a break for the 24 rising romClk edges of a word (8 sent, 16 received). It falls only after the 16th data bit.
- R7: romDi is 0 whenever romCs is low and whenever the block is receiving data.
- R8: The first word read appears in stationWord[47:32], the second in [31:16] and the third in [15:0].
- R9: done is high for exactly one cycle. It is first high in the cycle that follows the edge 222*PHASE_CYCLES clock edges after the edge that captured start. busy is high in between and falls together with the rise of done.
- R10: A start pulse while busy is high is ignored. The run length, the words read and the result do not change.
- R11: Every phase lasts exactly PHASE_CYCLES system clock cycles, and the sequencer changes state only at phase boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a load run (ignored while busy) |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse when all words are stored |
| stationWord | output | 48 | Loaded words, first word in the top slot |
| romCs | output | 1 | Chip select to the memory |
| romClk | output | 1 | Serial clock to the memory |
| romDi | output | 1 | Serial data into the memory |
| romDo | input | 1 | Serial data out of the memory |

## Verification
done and the falling busy are due 222*PHASE_CYCLES edges after the edge that captured start. The bench counts falling system clock edges from there and compares the count with that number, which it works out from the frame layout. Every memory pin goes through exactly one register after the sequencer state. So each phase appears on the pins exactly one cycle after the state changes, and the bench measures widths and gaps in whole cycles, not against absolute times. A behavioural memory model reacts to rising romClk edges and records each opcode and address. It drives its data on the rising clock edge, a full phase before the block samples it. All outputs are read at falling clock edges, so each check sees settled values.

// File: rtl/romld_pkg.sv
package romld_pkg;

  // Sequencer states for one load run
  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_LEAD,
    SEQ_SEND,
    SEQ_RECV,
    SEQ_TAIL
  } seqState_t;

  // Strobes handed from the sequencer to the datapath
  typedef struct packed {
    logic csLvl;      // next chip select level
    logic clkLvl;     // next serial clock level
    logic diLvl;      // next data level toward the memory
    logic sampleBit;  // capture romDo into the word shifter
    logic storeWord;  // move the finished word into its slot
    logic clearAll;   // clear result slots at run start
  } pinStrobe_t;

  localparam int OPCODE_BITS = 3;
  localparam logic [OPCODE_BITS-1:0] READ_OPCODE = 3'b110;

endpackage

// File: rtl/romld_ctrl.sv
module romld_ctrl
  import romld_pkg::*;
#(
  parameter int PHASE_CYCLES = 25,
  parameter int WORD_COUNT   = 3,
  parameter int START_ADDR   = 10,
  parameter int ADDR_BITS    = 5,
  parameter int WORD_BITS    = 16,
  localparam int CNT_W   = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1,
  localparam int SEND_BITS = OPCODE_BITS + ADDR_BITS,
  localparam int MAX_BITS  = (SEND_BITS > WORD_BITS) ? SEND_BITS : WORD_BITS,
  localparam int BIT_W   = (MAX_BITS > 1) ? $clog2(MAX_BITS) : 1,
  localparam int WIDX_W  = (WORD_COUNT > 1) ? $clog2(WORD_COUNT) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic [WIDX_W-1:0] wordSlot,
  output pinStrobe_t        strb
);

  seqState_t         curState;
  logic [CNT_W-1:0]  phaseCnt;
  logic [1:0]        subPh;
  logic [BIT_W-1:0]  bitIdx;
  logic [WIDX_W-1:0] wordIdx;
  logic              phaseTick;
  logic              lastSub;
  logic              lastSendBit;
  logic              lastRecvBit;
  logic              lastWord;
  logic [ADDR_BITS-1:0] wordAddr;
  logic [SEND_BITS-1:0] cmdFrame;
  logic              txBit;

  assign phaseTick   = (phaseCnt == CNT_W'(PHASE_CYCLES - 1));
  assign lastSub     = (subPh == 2'd2);
  assign lastSendBit = (bitIdx == BIT_W'(SEND_BITS - 1));
  assign lastRecvBit = (bitIdx == BIT_W'(WORD_BITS - 1));
  assign lastWord    = (wordIdx == WIDX_W'(WORD_COUNT - 1));
  assign wordSlot    = wordIdx;

  // Address of the word being fetched, and the frame sent for it
  always_comb begin
    wordAddr = ADDR_BITS'(START_ADDR) + ADDR_BITS'(wordIdx);
    cmdFrame = {READ_OPCODE, wordAddr};
  end

  // Pick the frame bit for the current bit index, sent MSB first
  always_comb begin
    txBit = 1'b0;
    for (int i = 0; i < SEND_BITS; i++) begin
      if (bitIdx == BIT_W'(SEND_BITS - 1 - i)) txBit = cmdFrame[i];
    end
  end

  // Sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState <= SEQ_IDLE;
      phaseCnt <= '0;
      subPh    <= '0;
      bitIdx   <= '0;
      wordIdx  <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (curState == SEQ_IDLE) begin
        if (start) begin
          curState <= SEQ_LEAD;
          busy     <= 1'b1;
          phaseCnt <= '0;
          subPh    <= '0;
          bitIdx   <= '0;
          wordIdx  <= '0;
        end
      end else begin
        phaseCnt <= phaseTick ? '0 : phaseCnt + CNT_W'(1);
        if (phaseTick) begin
          unique case (curState)
            SEQ_LEAD: begin
              curState <= SEQ_SEND;
              subPh    <= '0;
              bitIdx   <= '0;
            end
            SEQ_SEND: begin
              if (lastSub) begin
                subPh <= '0;
                if (lastSendBit) begin
                  curState <= SEQ_RECV;
                  bitIdx   <= '0;
                end else begin
                  bitIdx <= bitIdx + BIT_W'(1);
                end
              end else begin
                subPh <= subPh + 2'd1;
              end
            end
            SEQ_RECV: begin
              if (lastSub) begin
                subPh <= '0;
                if (lastRecvBit) begin
                  curState <= SEQ_TAIL;
                  bitIdx   <= '0;
                end else begin
                  bitIdx <= bitIdx + BIT_W'(1);
                end
              end else begin
                subPh <= subPh + 2'd1;
              end
            end
            SEQ_TAIL: begin
              if (lastWord) begin
                curState <= SEQ_IDLE;
                busy     <= 1'b0;
                done     <= 1'b1;
              end else begin
                wordIdx  <= wordIdx + WIDX_W'(1);
                curState <= SEQ_LEAD;
              end
            end
            default: curState <= SEQ_IDLE;
          endcase
        end
      end
    end
  end

  // Strobes toward the datapath
  always_comb begin
    strb = '0;
    strb.csLvl     = (curState == SEQ_SEND) || (curState == SEQ_RECV);
    strb.clkLvl    = ((curState == SEQ_SEND) && (subPh == 2'd1)) ||
                     ((curState == SEQ_RECV) && (subPh != 2'd2));
    strb.diLvl     = (curState == SEQ_SEND) && txBit;
    strb.sampleBit = (curState == SEQ_RECV) && (subPh == 2'd1) && phaseTick;
    strb.storeWord = (curState == SEQ_RECV) && lastSub && phaseTick && lastRecvBit;
    strb.clearAll  = (curState == SEQ_IDLE) && start;
  end

  AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (curState != SEQ_IDLE && !phaseTick) |=> (curState == $past(curState))); // R11

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R9

endmodule

// File: rtl/romld_dp.sv
module romld_dp
  import romld_pkg::*;
#(
  parameter int WORD_COUNT = 3,
  parameter int WORD_BITS  = 16,
  localparam int WIDX_W  = (WORD_COUNT > 1) ? $clog2(WORD_COUNT) : 1,
  localparam int BCNT_W  = $clog2(WORD_BITS + 1),
  localparam int TOTAL_W = WORD_COUNT * WORD_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  pinStrobe_t         strb,
  input  logic [WIDX_W-1:0]  wordSlot,
  input  logic               romDo,
  output logic               romCs,
  output logic               romClk,
  output logic               romDi,
  output logic [TOTAL_W-1:0] stationWord
);

  logic [WORD_BITS-1:0] wordSr;
  logic [WORD_BITS-1:0] slotQ [WORD_COUNT];
  logic [BCNT_W-1:0]    bitsIn;

  // Registered pins toward the memory
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romCs  <= 1'b0;
      romClk <= 1'b0;
      romDi  <= 1'b0;
    end else begin
      romCs  <= strb.csLvl;
      romClk <= strb.clkLvl;
      romDi  <= strb.diLvl;
    end
  end

  // Incoming word shifter and bit counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordSr <= '0;
      bitsIn <= '0;
    end else begin
      if (strb.sampleBit) begin
        wordSr <= {wordSr[WORD_BITS-2:0], romDo};
        bitsIn <= bitsIn + BCNT_W'(1);
      end else if (!strb.csLvl) begin
        bitsIn <= '0;
      end
    end
  end

  // Result slots
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < WORD_COUNT; w++) slotQ[w] <= '0;
    end else if (strb.clearAll) begin
      for (int w = 0; w < WORD_COUNT; w++) slotQ[w] <= '0;
    end else if (strb.storeWord) begin
      for (int w = 0; w < WORD_COUNT; w++) begin
        if (wordSlot == WIDX_W'(w)) slotQ[w] <= wordSr;
      end
    end
  end

  // First slot goes to the most significant end
  generate
    for (genvar g = 0; g < WORD_COUNT; g++) begin : g_pack
      assign stationWord[(WORD_COUNT-1-g)*WORD_BITS +: WORD_BITS] = slotQ[g];
    end
  endgenerate

  AST_CS_FULL_WORD: assert property (@(posedge clk) disable iff (!rstN)
    $fell(romCs) |-> ($past(bitsIn) == BCNT_W'(WORD_BITS))); // R6

  AST_DI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (romClk && $past(romClk)) |-> $stable(romDi)); // R4

endmodule

// File: rtl/romld_top.sv
module romld_top
  import romld_pkg::*;
#(
  parameter int PHASE_CYCLES = 25,
  parameter int WORD_COUNT   = 3,
  parameter int START_ADDR   = 10,
  parameter int ADDR_BITS    = 5,
  parameter int WORD_BITS    = 16,
  localparam int WIDX_W  = (WORD_COUNT > 1) ? $clog2(WORD_COUNT) : 1,
  localparam int TOTAL_W = WORD_COUNT * WORD_BITS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  output logic               busy,
  output logic               done,
  output logic [TOTAL_W-1:0] stationWord,
  output logic               romCs,
  output logic               romClk,
  output logic               romDi,
  input  logic               romDo
);

  pinStrobe_t        strb;
  logic [WIDX_W-1:0] wordSlot;

  romld_ctrl #(
    .PHASE_CYCLES(PHASE_CYCLES),
    .WORD_COUNT  (WORD_COUNT),
    .START_ADDR  (START_ADDR),
    .ADDR_BITS   (ADDR_BITS),
    .WORD_BITS   (WORD_BITS)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .wordSlot(wordSlot),
    .strb    (strb)
  );

  romld_dp #(
    .WORD_COUNT(WORD_COUNT),
    .WORD_BITS (WORD_BITS)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wordSlot   (wordSlot),
    .romDo      (romDo),
    .romCs      (romCs),
    .romClk     (romClk),
    .romDi      (romDi),
    .stationWord(stationWord)
  );

  AST_DI_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy || !romCs) |-> !romDi); // R7

endmodule

// File: tb/romld_top_tb.sv
module romld_top_tb;

  localparam int PH  = 3;
  localparam int NW  = 3;
  localparam int WB  = 16;
  localparam int AB  = 5;
  localparam int SA  = 10;
  localparam int EXP_LAT = NW * (2 + 3 * (3 + AB) + 3 * WB) * PH;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic busy, done, romCs, romClk, romDi;
  logic romDo = 1'b0;
  logic [NW*WB-1:0] stationWord;

  always #10 clk = ~clk;

  romld_top #(
    .PHASE_CYCLES(PH), .WORD_COUNT(NW), .START_ADDR(SA),
    .ADDR_BITS(AB), .WORD_BITS(WB)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
    .stationWord(stationWord), .romCs(romCs), .romClk(romClk),
    .romDi(romDi), .romDo(romDo)
  );

  int checks = 0;
  int fails  = 0;

  // Memory model and pin monitors
  logic [15:0] mem [32];
  int inCnt = 0, outIdx = 0, risesSeen = 0, wordsSeen = 0;
  logic [7:0] inReg = '0;
  int addrLog [8];
  int cmdErr = 0, frameErr = 0, gapErr = 0, widthErr = 0, diHoldErr = 0, diZeroErr = 0;
  int cyc = 0, fallCyc = 0, riseCyc = 0;
  bit gapValid = 0;
  logic lastClk = 0, lastDi = 0;

  always @(posedge romClk) begin
    riseCyc = cyc;
    if (romCs) begin
      risesSeen++;
      if (inCnt < 8) begin
        inReg = {inReg[6:0], romDi};
        inCnt++;
      end else if (outIdx < 16) begin
        romDo = mem[inReg[4:0]][15-outIdx];
        outIdx++;
      end
    end
  end

  always @(negedge romClk) begin
    int wExp;
    wExp = (outIdx == 0) ? PH : 2 * PH;
    if (cyc - riseCyc != wExp) widthErr++;
  end

  always @(negedge romCs) begin
    if (inReg[7:5] != 3'b110) cmdErr++;
    if (risesSeen != 24 || outIdx != 16) frameErr++;
    if (wordsSeen < 8) addrLog[wordsSeen] = int'(inReg[4:0]);
    wordsSeen++;
    fallCyc = cyc;
    gapValid = 1;
    inCnt = 0; outIdx = 0; risesSeen = 0;
    romDo = 1'b0;
  end

  always @(posedge romCs) begin
    if (gapValid && (cyc - fallCyc) != 2 * PH) gapErr++;
  end

  always @(negedge clk) begin
    cyc++;
    if (romClk && lastClk && romDi != lastDi) diHoldErr++;
    if (romDi && (!romCs || outIdx > 0)) diZeroErr++;
    lastClk = romClk;
    lastDi  = romDi;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic clearMonitors();
    wordsSeen = 0; gapValid = 0;
    cmdErr = 0; frameErr = 0; gapErr = 0; widthErr = 0; diHoldErr = 0; diZeroErr = 0;
    for (int i = 0; i < 8; i++) addrLog[i] = -1;
  endtask

  task automatic runLoad(input bit inject);
    int n;
    logic [47:0] expWord;
    clearMonitors();
    expWord = {mem[SA], mem[SA+1], mem[SA+2]};
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    n = 0;
    chk(busy == 1'b1, "R9", "busy after start", 64'(busy), 64'd1);
    while (!done && n < 5000) begin
      start = (inject && (n == 50 || n == 51 || n == 300)) ? 1'b1 : 1'b0;
      @(negedge clk);
      n++;
    end
    start = 1'b0;
    chk(n == EXP_LAT, inject ? "R10" : "R9", "cycles to done", 64'(n), 64'(EXP_LAT));
    chk(busy == 1'b0, "R9", "busy low with done", 64'(busy), 64'd0);
    chk(stationWord == expWord, "R5", "loaded data", 64'(stationWord), 64'(expWord));
    chk(stationWord[47:32] == mem[SA], "R8", "first word slot",
        64'(stationWord[47:32]), 64'(mem[SA]));
    @(negedge clk);
    chk(done == 1'b0, "R9", "done width", 64'(done), 64'd0);
    chk(wordsSeen == NW, inject ? "R10" : "R6", "words framed", 64'(wordsSeen), 64'(NW));
    for (int k = 0; k < NW; k++)
      chk(addrLog[k] == SA + k, "R3", "word address", 64'(addrLog[k]), 64'(SA + k));
    chk(cmdErr == 0, "R3", "opcode errors", 64'(cmdErr), 64'd0);
    chk(frameErr == 0, "R6", "cs frame errors", 64'(frameErr), 64'd0);
    chk(gapErr == 0, "R2", "inter-word low gap errors", 64'(gapErr), 64'd0);
    chk(widthErr == 0, "R11", "clock high width errors", 64'(widthErr), 64'd0);
    chk(diHoldErr == 0, "R4", "data moved during clock high", 64'(diHoldErr), 64'd0);
    chk(diZeroErr == 0, "R7", "data high while idle or receiving", 64'(diZeroErr), 64'd0);
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'd4242);
    for (int i = 0; i < 32; i++) mem[i] = 16'($urandom());
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(busy == 0 && done == 0, "R1", "flags in reset", {62'd0, busy, done}, 64'd0);
    chk(romCs == 0 && romClk == 0 && romDi == 0, "R1", "pins in reset",
        {61'd0, romCs, romClk, romDi}, 64'd0);
    chk(stationWord == '0, "R1", "result in reset", 64'(stationWord), 64'd0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 0 && romCs == 0, "R1", "idle after reset", {62'd0, busy, romCs}, 64'd0);

    // Directed corner patterns
    mem[SA] = 16'hFFFF; mem[SA+1] = 16'h0000; mem[SA+2] = 16'h8001;
    runLoad(1'b0);
    mem[SA] = 16'hA5A5; mem[SA+1] = 16'h5A5A; mem[SA+2] = 16'h0001;
    runLoad(1'b0);
    // R10 start pulses while busy
    runLoad(1'b1);
    // Random contents
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 32; i++) mem[i] = 16'($urandom());
      repeat (1 + ($urandom() % 5)) @(negedge clk);
      runLoad(r == 3);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule